// File: doc/BRIEF.md
# Receive Status Ring Writer

This block sits in a receive DMA engine and keeps a ring of 8-byte status entries in system memory. Software gives it a ring base address and a ring length in bytes. It returns free entries in bulk by writing a count to an enqueue selector. Each time the receive path finishes a frame, it offers the frame's outcome on a valid/ready pair. The block then formats a two-word status entry and writes it to memory at the current ring address. After the write, the current address steps to the next entry and wraps back to the base at the end of the ring.

Each completed entry raises a one-cycle status event for the interrupt logic. The block refuses a frame while it holds no free entries, so that software never finds an entry overwritten before it has consumed it. The held frame is written as soon as software enqueues more entries. The current address and the free-entry count are brought out so that the surrounding register file can expose them.

Top module: `rsq_writer`

## Requirements
- R1: After reset, `mem_we_o`, `stat_evt_o` and `frm_ready_o` are 0, and `cur_addr_o` and `free_cnt_o` are 0.
- R2: A configuration write with `cfg_sel_i` = 2 (enqueue) adds the low `CNT_W` bits of `cfg_wdata_i` to the free-entry count. The new count is visible on the next cycle.
- R3: When a frame is accepted (`frm_valid_i` and `frm_ready_o` high at a clock edge), `mem_we_o` and `stat_evt_o` are high for exactly the following cycle. In that cycle `mem_addr_o` equals the current address held before the accept.
- R4: Status word 0 is `mem_wdata_o[31:0]`. Its bits are: bit 31 = 1 (entry valid), 30 error-free, 29 end of frame, 28 end of buffer, 20 overrun, 19 framing error, 18 runt, 17 extra data, 16 CRC error, and 15 CRC kept. All other bits are 0.
- R5: Status word 1 is `mem_wdata_o[63:32]`. Its bits are: bit 31 = 1 (entry valid), bits 30:16 = `frm_buf_idx_i`, and bits 15:0 = the reported length.
- R6: The reported length equals `frm_len_i` + 4 when `frm_crc_kept_i` is 1, and `frm_len_i` otherwise.
- R7: Each accepted frame advances `cur_addr_o` by 8. When the advanced address reaches base + length, it becomes the base instead.
- R8: A configuration write with `cfg_sel_i` = 0 sets both the base and `cur_addr_o` to `cfg_wdata_i`. A write with `cfg_sel_i` = 1 sets the ring length in bytes.
- R9: While the free count is 0, `frm_ready_o` is 0 and no entry is written, however long `frm_valid_i` is held. Once entries are enqueued, the held frame is written.
- R10: Each accepted frame takes one free entry. An enqueue of N on the same edge as an accept leaves the count at old + N - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | 0 base, 1 length, 2 enqueue |
| cfg_wdata_i | input | AW | Configuration write data |
| frm_valid_i | input | 1 | Completed frame offered |
| frm_ready_o | output | 1 | A free entry is available |
| frm_ok_i | input | 1 | Frame received without error |
| frm_eof_i | input | 1 | End of frame |
| frm_eob_i | input | 1 | End of buffer |
| frm_overrun_i | input | 1 | FIFO overrun |
| frm_framing_i | input | 1 | Framing error |
| frm_runt_i | input | 1 | Runt frame |
| frm_extra_i | input | 1 | Extra data |
| frm_crc_err_i | input | 1 | CRC error |
| frm_crc_kept_i | input | 1 | FCS kept in buffer |
| frm_buf_idx_i | input | 15 | Buffer index from descriptor |
| frm_len_i | input | 16 | Frame length without FCS |
| mem_we_o | output | 1 | Entry write strobe |
| mem_addr_o | output | AW | Entry byte address |
| mem_wdata_o | output | 64 | Word 1 in [63:32], word 0 in [31:0] |
| stat_evt_o | output | 1 | One-cycle status event |
| cur_addr_o | output | AW | Current ring address |
| free_cnt_o | output | CNT_W | Free entries held |

## Verification
The bench uses a four-entry ring to reach the wrap point. A design that compared against the wrong end address would write past the ring or restart one entry early. It also drains the free count to zero and holds a frame offered there. A design that underflowed the count would accept the frame and overwrite an entry software still owns. An enqueue that lands on the same edge as an accept shows whether one of the two updates is lost. Frames are sent with every error flag set and with the FCS kept. This exposes misplaced flag bits and a length that skips the 4-byte adjustment.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_LEN  = 2'd1,
        CFG_ENQ  = 2'd2
    } cfg_sel_e;

    localparam int IDX_W       = 15;
    localparam int LEN_W       = 16;
    localparam int WORD_W      = 32;
    localparam int ENTRY_BYTES = 8;
    localparam int FCS_BYTES   = 4;

    // status word bit positions (decoded by software)
    localparam int B_VALID   = 31;
    localparam int B_OK      = 30;
    localparam int B_EOF     = 29;
    localparam int B_EOB     = 28;
    localparam int B_OVR     = 20;
    localparam int B_FRM     = 19;
    localparam int B_RUNT    = 18;
    localparam int B_EXTRA   = 17;
    localparam int B_CRCERR  = 16;
    localparam int B_CRCKEPT = 15;
    localparam int IDX_LSB   = 16;

    typedef struct packed {
        logic              ok;
        logic              eof;
        logic              eob;
        logic              ovr;
        logic              frm;
        logic              runt;
        logic              extra;
        logic              crc_err;
        logic              crc_kept;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  len;
    } rx_done_t;

    function automatic logic [WORD_W-1:0] pack_word0(input rx_done_t f);
        logic [WORD_W-1:0] w;
        w            = '0;
        w[B_VALID]   = 1'b1;
        w[B_OK]      = f.ok;
        w[B_EOF]     = f.eof;
        w[B_EOB]     = f.eob;
        w[B_OVR]     = f.ovr;
        w[B_FRM]     = f.frm;
        w[B_RUNT]    = f.runt;
        w[B_EXTRA]   = f.extra;
        w[B_CRCERR]  = f.crc_err;
        w[B_CRCKEPT] = f.crc_kept;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word1(input rx_done_t f);
        logic [WORD_W-1:0] w;
        logic [LEN_W-1:0]  l;
        l = f.crc_kept ? f.len + LEN_W'(FCS_BYTES) : f.len;
        w = '0;
        w[B_VALID] = 1'b1;
        w[IDX_LSB +: IDX_W] = f.idx;
        w[LEN_W-1:0] = l;
        return w;
    endfunction

endpackage

// File: rtl/rsq_ring.sv
module rsq_ring #(
    parameter int AW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          base_we_i,
    input  logic          len_we_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          adv_i,
    output logic [AW-1:0] cur_o
);
    import rsq_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(ENTRY_BYTES);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] len;
        logic [AW-1:0] cur;
    } ring_t;

    ring_t s_d, s_q;
    logic [AW-1:0] step_addr;

    always_comb begin
        s_d       = s_q;
        step_addr = s_q.cur + STEP;
        if (adv_i) begin
            if ((step_addr - s_q.base) >= s_q.len) begin
                s_d.cur = s_q.base;
            end else begin
                s_d.cur = step_addr;
            end
        end
        if (len_we_i) begin
            s_d.len = wdata_i;
        end
        if (base_we_i) begin
            s_d.base = wdata_i;
            s_d.cur  = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_o = s_q.cur;

    // R7
    step_or_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !base_we_i) |=>
            (s_q.cur == $past(s_q.cur) + STEP) || (s_q.cur == s_q.base));

    // R8
    base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        base_we_i |=> (cur_o == $past(wdata_i)));

endmodule

// File: rtl/rsq_credit.sv
module rsq_credit #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enq_we_i,
    input  logic [CNT_W-1:0] enq_cnt_i,
    input  logic             take_i,
    output logic [CNT_W-1:0] free_o,
    output logic             avail_o
);
    typedef struct packed {
        logic [CNT_W-1:0] free;
    } credit_t;

    credit_t c_d, c_q;
    logic [CNT_W-1:0] add_amt;

    always_comb begin
        c_d     = c_q;
        add_amt = enq_we_i ? enq_cnt_i : '0;
        c_d.free = c_q.free + add_amt - CNT_W'(take_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign free_o  = c_q.free;
    assign avail_o = (c_q.free != '0);

    // R9
    no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (free_o == '0 && !enq_we_i) |=> (free_o == '0));

endmodule

// File: rtl/rsq_fmt.sv
module rsq_fmt #(
    parameter int AW = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [AW-1:0]     addr_i,
    input  rsq_pkg::rx_done_t frm_i,
    output logic              we_o,
    output logic [AW-1:0]     addr_o,
    output logic [63:0]       data_o
);
    import rsq_pkg::*;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [63:0]   data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d    = o_q;
        o_d.we = load_i;
        if (load_i) begin
            o_d.addr = addr_i;
            o_d.data = {pack_word1(frm_i), pack_word0(frm_i)};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign we_o   = o_q.we;
    assign addr_o = o_q.addr;
    assign data_o = o_q.data;

    // R4
    valid_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_o |-> (data_o[63] && data_o[31]));

endmodule

// File: rtl/rsq_writer.sv
module rsq_writer #(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_sel_i,
    input  logic [AW-1:0]    cfg_wdata_i,
    input  logic             frm_valid_i,
    output logic             frm_ready_o,
    input  logic             frm_ok_i,
    input  logic             frm_eof_i,
    input  logic             frm_eob_i,
    input  logic             frm_overrun_i,
    input  logic             frm_framing_i,
    input  logic             frm_runt_i,
    input  logic             frm_extra_i,
    input  logic             frm_crc_err_i,
    input  logic             frm_crc_kept_i,
    input  logic [14:0]      frm_buf_idx_i,
    input  logic [15:0]      frm_len_i,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [63:0]      mem_wdata_o,
    output logic             stat_evt_o,
    output logic [AW-1:0]    cur_addr_o,
    output logic [CNT_W-1:0] free_cnt_o
);
    import rsq_pkg::*;

    logic      accept;
    logic      avail;
    logic      base_we, len_we, enq_we;
    rx_done_t  frm;

    assign base_we = cfg_we_i && (cfg_sel_i == CFG_BASE);
    assign len_we  = cfg_we_i && (cfg_sel_i == CFG_LEN);
    assign enq_we  = cfg_we_i && (cfg_sel_i == CFG_ENQ);

    assign accept      = frm_valid_i && avail;
    assign frm_ready_o = avail;

    always_comb begin
        frm.ok       = frm_ok_i;
        frm.eof      = frm_eof_i;
        frm.eob      = frm_eob_i;
        frm.ovr      = frm_overrun_i;
        frm.frm      = frm_framing_i;
        frm.runt     = frm_runt_i;
        frm.extra    = frm_extra_i;
        frm.crc_err  = frm_crc_err_i;
        frm.crc_kept = frm_crc_kept_i;
        frm.idx      = frm_buf_idx_i;
        frm.len      = frm_len_i;
    end

    rsq_ring #(.AW(AW)) ring_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .base_we_i (base_we),
        .len_we_i  (len_we),
        .wdata_i   (cfg_wdata_i),
        .adv_i     (accept),
        .cur_o     (cur_addr_o)
    );

    rsq_credit #(.CNT_W(CNT_W)) credit_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enq_we_i  (enq_we),
        .enq_cnt_i (cfg_wdata_i[CNT_W-1:0]),
        .take_i    (accept),
        .free_o    (free_cnt_o),
        .avail_o   (avail)
    );

    rsq_fmt #(.AW(AW)) fmt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (accept),
        .addr_i (cur_addr_o),
        .frm_i  (frm),
        .we_o   (mem_we_o),
        .addr_o (mem_addr_o),
        .data_o (mem_wdata_o)
    );

    assign stat_evt_o = mem_we_o;

    // R3
    wr_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> $past(frm_valid_i && frm_ready_o));

    // R3
    wr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frm_valid_i && frm_ready_o) |=> (mem_addr_o == $past(cur_addr_o)));

endmodule

// File: tb/rsq_writer_tb_top.sv
module rsq_writer_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic        fv = 0;
    logic        fready;
    logic        f_ok = 0, f_eof = 0, f_eob = 0, f_ovr = 0, f_frm = 0;
    logic        f_runt = 0, f_extra = 0, f_crcerr = 0, f_kept = 0;
    logic [14:0] f_idx = 0;
    logic [15:0] f_len = 0;
    logic        mwe, evt;
    logic [31:0] maddr, cur;
    logic [63:0] mdata;
    logic [15:0] freec;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    rsq_writer dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
        .frm_valid_i(fv), .frm_ready_o(fready),
        .frm_ok_i(f_ok), .frm_eof_i(f_eof), .frm_eob_i(f_eob),
        .frm_overrun_i(f_ovr), .frm_framing_i(f_frm), .frm_runt_i(f_runt),
        .frm_extra_i(f_extra), .frm_crc_err_i(f_crcerr), .frm_crc_kept_i(f_kept),
        .frm_buf_idx_i(f_idx), .frm_len_i(f_len),
        .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mdata),
        .stat_evt_o(evt), .cur_addr_o(cur), .free_cnt_o(freec)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
        cfg_sel = sel; cfg_wdata = d; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_frame(input logic [8:0] flags, input logic [14:0] idx, input logic [15:0] len);
        {f_ok, f_eof, f_eob, f_ovr, f_frm, f_runt, f_extra, f_crcerr, f_kept} = flags;
        f_idx = idx; f_len = len;
    endtask

    // offer one frame while ready, check the write in the following cycle
    task automatic send_check(input string req, input logic [31:0] exp_addr,
                              input logic [63:0] exp_data);
        fv = 1;
        chk({req, " ready"}, 64'(fready), 64'd1);
        @(negedge clk);
        fv = 0;
        chk({req, " we"}, 64'(mwe), 64'd1);
        chk({req, " evt"}, 64'(evt), 64'd1);
        chk({req, " addr"}, 64'(maddr), 64'(exp_addr));
        chk({req, " data"}, mdata, exp_data);
    endtask

    task automatic t_reset;
        chk("R1 we", 64'(mwe), 0);
        chk("R1 evt", 64'(evt), 0);
        chk("R1 ready", 64'(fready), 0);
        chk("R1 cur", 64'(cur), 0);
        chk("R1 free", 64'(freec), 0);
    endtask

    task automatic t_setup;
        cfg(2'd0, 32'h1000);
        chk("R8 cur=base", 64'(cur), 64'h1000);
        cfg(2'd1, 32'd32);
        cfg(2'd2, 32'd3);
        chk("R2 free after enqueue", 64'(freec), 3);
    endtask

    task automatic t_basic;
        set_frame(9'b111_000000, 15'd5, 16'd60);
        send_check("R3 R4 R5 basic", 32'h1000, {32'h8005_003C, 32'hF000_0000});
        chk("R7 step", 64'(cur), 64'h1008);
        chk("R10 take", 64'(freec), 2);
        @(negedge clk);
        chk("R3 one-cycle pulse", 64'(mwe), 0);
    endtask

    task automatic t_errors;
        set_frame(9'b011_111111, 15'h7FFF, 16'd100);
        send_check("R4 R6 errors fcs kept", 32'h1008, {32'hFFFF_0068, 32'hB01F_8000});
    endtask

    task automatic t_hold;
        set_frame(9'b111_000000, 15'd2, 16'd64);
        send_check("R5 third", 32'h1010, {32'h8002_0040, 32'hF000_0000});
        chk("R9 free zero", 64'(freec), 0);
        set_frame(9'b110_000000, 15'd3, 16'd1500);
        fv = 1;
        for (int i = 0; i < 3; i++) begin
            chk("R9 not ready", 64'(fready), 0);
            @(negedge clk);
            chk("R9 held no write", 64'(mwe), 0);
        end
        cfg(2'd2, 32'd2);
        chk("R9 no write on enqueue edge", 64'(mwe), 0);
        send_check("R9 released", 32'h1018, {32'h8003_05DC, 32'hE000_0000});
        chk("R7 wrap to base", 64'(cur), 64'h1000);
        chk("R10 after release", 64'(freec), 1);
    endtask

    task automatic t_simul;
        set_frame(9'b111_000001, 15'd9, 16'd200);
        fv = 1;
        cfg_sel = 2'd2; cfg_wdata = 32'd5; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0; fv = 0;
        chk("R10 enqueue with accept", 64'(freec), 5);
        chk("R6 length +4", 64'(mdata[47:32]), 64'd204);
        chk("R3 addr", 64'(maddr), 64'h1000);
    endtask

    task automatic t_rebase;
        cfg(2'd0, 32'h2000);
        chk("R8 rebase cur", 64'(cur), 64'h2000);
        set_frame(9'b100_000000, 15'd1, 16'd0);
        send_check("R8 write at new base", 32'h2000, {32'h8001_0000, 32'hC000_0000});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_setup();
        t_basic();
        t_errors();
        t_hold();
        t_simul();
        t_rebase();
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule